// File: doc/BRIEF.md
# Blocking Inter-Core Message Queue

This block is a one-way hardware queue between two cores. A main thread pushes typed messages and a helper thread pops them. The helper does security tracking. Each message is a 2-bit kind plus a 32-bit payload. The kind says whether the payload carries branch flags, the address register of an indirect memory reference, an indirect jump target, or a safe-to-proceed token.

Every accepted message spends a fixed, parameterised transit time in the queue before the consumer may take it. This models the wire and buffer delay between the two cores.

Neither side needs a lock or a handshake flag. A push into a queue with no free slot stalls the producer. A pop with no visible message stalls the consumer. The stall alone orders the two threads. When no stall applies, each side completes its operation in a single cycle.

Top module: `xcore_msg_queue`

## Requirements
- R1: While `rst_ni` is low, both stall outputs are 0 whatever the requests. Reset discards every entry, including entries still in transit, so a pop request after reset stalls until new data is pushed and has aged.
- R2: Messages leave in exactly the order they were accepted, with kind and payload unchanged, and none is lost or duplicated.
- R3: A message accepted in cycle t is never popped before cycle t+LATENCY. If it is at the head and a pop is requested in cycle t+LATENCY, the pop completes in that cycle.
- R4: Occupancy counts both in-transit and ready entries. A push requested while occupancy equals DEPTH raises `enq_stall_o` and is not accepted. The message is kept by the producer and accepted in the first cycle with free space.
- R5: A pop request raises `deq_stall_o` when the queue is empty or when its head entry is still in transit.
- R6: A push with `enq_stall_o` low, and a pop with `deq_stall_o` low, each complete at the next clock edge. Both may complete in the same cycle, and the occupancy is then unchanged.
- R7: Kind codes pass through unchanged: 0 = branch flags, 1 = memory address register, 2 = jump target, 3 = safe-to-proceed token.
- R8: `enq_stall_o` is 0 whenever `enq_valid_i` is 0. `deq_stall_o` is 0 whenever `deq_req_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock shared by both sides |
| rst_ni | input | 1 | Asynchronous active-low reset |
| enq_valid_i | input | 1 | Producer requests a push this cycle |
| enq_kind_i | input | 2 | Kind of the pushed message |
| enq_data_i | input | 32 | Payload of the pushed message |
| enq_stall_o | output | 1 | Push cannot complete this cycle |
| deq_req_i | input | 1 | Consumer requests a pop this cycle |
| deq_kind_o | output | 2 | Kind of the head message |
| deq_data_o | output | 32 | Payload of the head message |
| deq_stall_o | output | 1 | Pop cannot complete this cycle |

## Verification
A push and a pop can complete in the same cycle. The hard case is a full queue, where the pop frees a slot but the push is still refused.

Request patterns keep both sides asking at once: always-on, interleaved at different rates, and a consumer held off until the queue has filled. A bench model tracks the acceptance cycle of every message. From it the model predicts, cycle by cycle, both stall outputs and the payload that must appear at each completed pop. Any slip in occupancy or age then shows up as a wrong stall or a wrong payload.

// File: rtl/xq_pkg.sv
package xq_pkg;
  localparam int unsigned KIND_W = 2;

  typedef enum logic [KIND_W-1:0] {
    XQ_BRANCH_FLAGS = 2'd0,
    XQ_MEM_ADDR     = 2'd1,
    XQ_JUMP_TGT     = 2'd2,
    XQ_SAFE_TOKEN   = 2'd3
  } xq_kind_e;
endpackage

// File: rtl/xq_ptr_ctrl.sv
module xq_ptr_ctrl #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  output logic [AW-1:0] wr_ptr_o,
  output logic [AW-1:0] rd_ptr_o,
  output logic [CW-1:0] occ_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] occ_q;

  function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      occ_q <= '0;
    end else begin
      if (push_i) wr_q <= wrap_inc(wr_q);
      if (pop_i)  rd_q <= wrap_inc(rd_q);
      if (push_i && !pop_i)      occ_q <= occ_q + CW'(1);
      else if (pop_i && !push_i) occ_q <= occ_q - CW'(1);
    end
  end

  assign wr_ptr_o = wr_q;
  assign rd_ptr_o = rd_q;
  assign occ_o    = occ_q;
  assign full_o   = (occ_q == CW'(DEPTH));
  assign empty_o  = (occ_q == '0);
endmodule

// File: rtl/xq_transit.sv
module xq_transit #(
  parameter int unsigned DEPTH   = 8,
  parameter int unsigned LATENCY = 10,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned TW = $clog2(LATENCY + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [AW-1:0] wr_ptr_i,
  input  logic [AW-1:0] rd_ptr_i,
  output logic          head_aged_o
);
  // first decrement happens on the edge after the write
  localparam logic [TW-1:0] LOAD = TW'(LATENCY - 1);

  logic [TW-1:0] tmr [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [TW-1:0] t_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                t_q <= '0;
      else if (push_i && wr_ptr_i == AW'(i))      t_q <= LOAD;
      else if (t_q != '0)                         t_q <= t_q - TW'(1);
    end
    assign tmr[i] = t_q;
  end

  assign head_aged_o = (tmr[rd_ptr_i] == '0);
endmodule

// File: rtl/xq_store.sv
module xq_store #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned W     = 34,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/xcore_msg_queue.sv
module xcore_msg_queue #(
  parameter int unsigned DEPTH   = 8,
  parameter int unsigned LATENCY = 10,
  parameter int unsigned DATA_W  = 32,
  localparam int unsigned KW = xq_pkg::KIND_W,
  localparam int unsigned EW = KW + DATA_W,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enq_valid_i,
  input  logic [KW-1:0]     enq_kind_i,
  input  logic [DATA_W-1:0] enq_data_i,
  output logic              enq_stall_o,
  input  logic              deq_req_i,
  output logic [KW-1:0]     deq_kind_o,
  output logic [DATA_W-1:0] deq_data_o,
  output logic              deq_stall_o
);
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] occ;
  logic          full, empty, head_aged, head_ok, push, pop;
  logic [EW-1:0] rd_entry;

  assign head_ok = head_aged && !empty;
  assign push    = enq_valid_i && !full;
  assign pop     = deq_req_i && head_ok;

  assign enq_stall_o = rst_ni && enq_valid_i && full;
  assign deq_stall_o = rst_ni && deq_req_i && !head_ok;

  xq_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk_i, .rst_ni,
    .push_i(push), .pop_i(pop),
    .wr_ptr_o(wr_ptr), .rd_ptr_o(rd_ptr),
    .occ_o(occ), .full_o(full), .empty_o(empty)
  );

  xq_transit #(.DEPTH(DEPTH), .LATENCY(LATENCY)) u_transit (
    .clk_i, .rst_ni,
    .push_i(push), .wr_ptr_i(wr_ptr), .rd_ptr_i(rd_ptr),
    .head_aged_o(head_aged)
  );

  xq_store #(.DEPTH(DEPTH), .W(EW)) u_store (
    .clk_i,
    .we_i(push), .waddr_i(wr_ptr), .wdata_i({enq_kind_i, enq_data_i}),
    .raddr_i(rd_ptr), .rdata_o(rd_entry)
  );

  assign {deq_kind_o, deq_data_o} = rd_entry;
endmodule

// File: rtl/xq_checker.sv
module xq_checker #(
  parameter int unsigned DEPTH   = 8,
  parameter int unsigned LATENCY = 10,
  localparam int unsigned CW = $clog2(DEPTH + 1),
  localparam int unsigned QW = $clog2(LATENCY + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          enq_valid_i,
  input logic          enq_stall_o,
  input logic          deq_req_i,
  input logic          deq_stall_o,
  input logic [CW-1:0] occ_i
);
  logic enq_fire, deq_fire;
  logic [QW-1:0] quiet_q;  // cycles since latest accepted push, saturating

  assign enq_fire = enq_valid_i && !enq_stall_o;
  assign deq_fire = deq_req_i && !deq_stall_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       quiet_q <= '0;
    else if (enq_fire)                 quiet_q <= QW'(1);
    else if (quiet_q != QW'(LATENCY))  quiet_q <= quiet_q + QW'(1);
  end

  assert_no_overflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ_i <= CW'(DEPTH));
  assert_full_holds_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enq_valid_i && enq_stall_o && !deq_fire) |=> occ_i == $past(occ_i));
  assert_empty_stalls_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (deq_req_i && occ_i == '0) |-> deq_stall_o);
  assert_push_grows_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enq_fire && !deq_fire) |=> occ_i == $past(occ_i) + CW'(1));
  assert_both_keep_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enq_fire && deq_fire) |=> occ_i == $past(occ_i));
  assert_min_transit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (deq_fire && occ_i == CW'(1)) |-> quiet_q == QW'(LATENCY));
  assert_gated_enq_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enq_valid_i |-> !enq_stall_o);
  assert_gated_deq_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !deq_req_i |-> !deq_stall_o);

  always_comb begin
    if (!rst_ni) assert_reset_quiet_R1: assert (!enq_stall_o && !deq_stall_o);
  end
endmodule

bind xcore_msg_queue xq_checker #(.DEPTH(DEPTH), .LATENCY(LATENCY)) chk_i (
  .clk_i, .rst_ni, .enq_valid_i, .enq_stall_o, .deq_req_i, .deq_stall_o,
  .occ_i(occ)
);

// File: tb/xcore_msg_queue_tb_top.sv
`timescale 1ns/1ps
module xcore_msg_queue_tb_top;
  localparam int DEPTH = 4;
  localparam int LAT   = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        enq_valid_i = 1'b0;
  logic [1:0]  enq_kind_i = '0;
  logic [31:0] enq_data_i = '0;
  logic        deq_req_i = 1'b0;
  logic        enq_stall_o, deq_stall_o;
  logic [1:0]  deq_kind_o;
  logic [31:0] deq_data_o;

  xcore_msg_queue #(.DEPTH(DEPTH), .LATENCY(LAT), .DATA_W(32)) dut_i (.*);

  always #5 clk_i = ~clk_i;

  int cyc = 0;
  always @(posedge clk_i) cyc <= cyc + 1;

  int total = 0, passed = 0, failed = 0;
  int acc_cyc [2048];
  int head = 0, tail = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (ok) passed++;
    else begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pay(input int s);
    return 32'hC0DE_0000 ^ 32'(s * 37);
  endfunction

  function automatic bit pick(input int p, input int c, input bit side);
    if (c >= 60) return side;  // drain phase: pop only
    case (p)
      0: return 1'b1;
      1: return side ? 1'b1 : (c % 3 == 0);
      2: return side ? (c % 2 == 0) : 1'b1;
      3: return side ? (c % 4 != 1) : (c % 5 != 0);
      default: return side ? (c >= 30) : 1'b1;
    endcase
  endfunction

  task automatic run_pattern(input int p);
    for (int c = 0; c < 100; c++) begin
      bit ev, dr, exp_es, exp_ds;
      int occ;
      @(negedge clk_i);
      ev = pick(p, c, 1'b0);
      dr = pick(p, c, 1'b1);
      enq_valid_i = ev;
      enq_kind_i  = 2'(tail);
      enq_data_i  = pay(tail);
      deq_req_i   = dr;
      #1;
      occ    = tail - head;
      exp_es = ev && occ == DEPTH;
      exp_ds = dr && !(occ > 0 && cyc >= acc_cyc[head] + LAT);
      if (!ev) chk(!enq_stall_o, "R8 enq_stall idle", 64'(enq_stall_o), 0);
      else     chk(enq_stall_o == exp_es, "R4 enq_stall", 64'(enq_stall_o), 64'(exp_es));
      if (!dr) chk(!deq_stall_o, "R8 deq_stall idle", 64'(deq_stall_o), 0);
      else     chk(deq_stall_o == exp_ds, "R3/R5 deq_stall", 64'(deq_stall_o), 64'(exp_ds));
      if (dr && !exp_ds) begin
        chk(deq_data_o == pay(head), "R2 payload", 64'(deq_data_o), 64'(pay(head)));
        chk(deq_kind_o == 2'(head), "R7 kind", 64'(deq_kind_o), 64'(2'(head)));
      end
      if (ev && !exp_es && dr && !exp_ds)
        chk(!enq_stall_o && !deq_stall_o, "R6 dual completion", 64'({enq_stall_o, deq_stall_o}), 0);
      if (ev && !exp_es) begin acc_cyc[tail] = cyc; tail++; end
      if (dr && !exp_ds) head++;
    end
    @(negedge clk_i);
    enq_valid_i = 0;
    deq_req_i = 0;
    chk(head == tail, "R2 all delivered", 64'(head), 64'(tail));
  endtask

  task automatic lat_probe(input logic [1:0] k, input logic [31:0] d);
    @(negedge clk_i);
    enq_valid_i = 1; enq_kind_i = k; enq_data_i = d; deq_req_i = 0;
    #1 chk(!enq_stall_o, "R6 push accepted", 64'(enq_stall_o), 0);
    @(negedge clk_i);
    enq_valid_i = 0; deq_req_i = 1;
    for (int j = 1; j <= LAT; j++) begin
      #1;
      chk(deq_stall_o == (j < LAT), "R3 exact transit", 64'(deq_stall_o), 64'(j < LAT));
      if (j == LAT) begin
        chk(deq_data_o == d, "R2 probe payload", 64'(deq_data_o), 64'(d));
        chk(deq_kind_o == k, "R7 probe kind", 64'(deq_kind_o), 64'(k));
      end
      @(negedge clk_i);
    end
    deq_req_i = 0;
  endtask

  initial begin
    #2_000_000;
    total++; failed++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end

  initial begin
    enq_valid_i = 1; deq_req_i = 1;
    #1 chk(!enq_stall_o && !deq_stall_o, "R1 stalls low in reset", 64'({enq_stall_o, deq_stall_o}), 0);
    repeat (3) @(negedge clk_i);
    enq_valid_i = 0;
    rst_ni = 1;
    #1 chk(deq_stall_o, "R1 empty after reset", 64'(deq_stall_o), 1);
    @(negedge clk_i);
    deq_req_i = 0;

    for (int p = 0; p < 5; p++) run_pattern(p);

    lat_probe(2'd0, 32'h0000_0001);
    lat_probe(2'd1, 32'hDEAD_BEEF);
    lat_probe(2'd2, 32'h8000_0000);
    lat_probe(2'd3, 32'hFFFF_FFFF);

    // reset with entries in transit
    @(negedge clk_i); enq_valid_i = 1; enq_kind_i = 2'd1; enq_data_i = 32'h1234_5678;
    @(negedge clk_i); enq_data_i = 32'h9ABC_DEF0;
    @(negedge clk_i); enq_valid_i = 0; deq_req_i = 1; rst_ni = 0;
    #1 chk(!enq_stall_o && !deq_stall_o, "R1 stalls low in reset", 64'({enq_stall_o, deq_stall_o}), 0);
    @(negedge clk_i); rst_ni = 1;
    for (int j = 0; j < LAT + 3; j++) begin
      #1 chk(deq_stall_o, "R1 transit discarded", 64'(deq_stall_o), 1);
      @(negedge clk_i);
    end
    deq_req_i = 0;

    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end
endmodule